// File: doc/BRIEF.md
# Partitioned Direct-Mapped Cache Lookup

This block is the tag side of a direct-mapped cache whose set index is reshaped per task. Each task owns a partition of the array. A partition is a run of equal segments that starts at an aligned base segment and spans a power-of-two number of segments. On each lookup, a partition number picks the active settings. The high bits of the set index are then taken from the address where they fall inside the partition's span, and from the partition base where they fall outside it. Every access of a task therefore lands inside that task's slice of the one array, and no other task can evict its lines.

The block computes the remapped set, compares the stored line address, and reports hit or miss one cycle after the request. On a miss it raises a refill request that carries the line address, and it writes the tag when the refill is acknowledged. It can also invalidate the lines of a single partition, one set per cycle. Partition settings are written through a small configuration port. A write whose base is not aligned to its size is rejected.

Top module: `seg_cache_lookup`

## Requirements
- R1: After reset, `resp_hit`, `resp_miss`, `refill_req`, `busy` and `cfg_err` are 0, every line is invalid, and every partition covers the whole cache (base 0, size code 4).
- R2: The set index is `req_addr[7:2]`. Its low two bits pass straight through. High bit i (set bit 2+i, address bit 4+i) comes from the address when i < size code, and from bit i of the partition base otherwise. `lookup_set` shows the result combinationally.
- R3: The size code k in 0..4 gives a partition of 2^k segments of 4 sets each.
- R4: One cycle after an accepted request, exactly one of `resp_hit`/`resp_miss` is high for one cycle. Hit means the remapped set is valid and its stored line address equals `req_addr[15:2]`.
- R5: A request reads and replaces only sets inside its own partition. A line filled by one partition survives accesses by a disjoint partition.
- R6: From the cycle after a miss, `refill_req` stays high with `refill_addr` equal to the missed `req_addr[15:2]` until `refill_ack` is sampled. The line is then written into the remapped set, and `resp_hit` is high in the following cycle.
- R7: A `flush_start` in an idle cycle invalidates only the sets of partition `flush_pid`, one per cycle, with `busy` high for exactly as many cycles as the partition has sets. It takes precedence over a request in the same cycle.
- R8: A configuration write with size code above 4, or with base bits below the size code not all zero, leaves the table unchanged and pulses `cfg_err` in the next cycle. A valid write takes effect from the next cycle.
- R9: While `busy` is high, requests are ignored: they give no response and change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Partition setting write strobe |
| cfg_pid | input | 2 | Partition number written |
| cfg_base | input | 4 | Base segment |
| cfg_log2 | input | 3 | Size code (log2 of segment count) |
| cfg_err | output | 1 | Rejected write, one cycle after it |
| req_valid | input | 1 | Lookup request |
| req_pid | input | 2 | Partition of the requester |
| req_addr | input | 16 | Byte address |
| lookup_set | output | 6 | Remapped set index |
| resp_hit | output | 1 | Hit response |
| resp_miss | output | 1 | Miss response |
| refill_req | output | 1 | Refill outstanding |
| refill_addr | output | 14 | Line address to refill |
| refill_ack | input | 1 | Refill data written |
| flush_start | input | 1 | Start partition invalidation |
| flush_pid | input | 2 | Partition to invalidate |
| busy | output | 1 | Refill or invalidation in progress |

## Verification
`lookup_set` is checked in the same cycle as its inputs. `resp_hit`/`resp_miss` and `cfg_err` are checked one cycle after the request or write edge, and `refill_req` from the cycle after a miss. The hit that follows a refill is checked one cycle after the acknowledge edge, and `busy` is checked on every cycle of an invalidation. The reference model advances on the same edge as the design and holds its expected values in registers. Comparison happens on the falling edge, so each result is compared in exactly the cycle it is due.

// File: rtl/segcache_pkg.sv
// Shared types for the partitioned cache lookup.
// Assumes nothing beyond IEEE 1800-2017.
package segcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_FLUSH = 2'd2
    } lk_state_e;
endpackage

// File: rtl/seg_part_table.sv
// Per-partition settings: base segment and size code.
// A write with a size code above SEG_W, or with base bits below the size
// code not all zero, is dropped and flagged one cycle later.
// Two read ports serve lookup and invalidation.
module seg_part_table #(
    parameter int NPART = 4,
    parameter int PID_W = 2,
    parameter int SEG_W = 4,
    parameter int LOG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PID_W-1:0] wid,
    input  logic [SEG_W-1:0] wbase,
    input  logic [LOG_W-1:0] wlog,
    output logic             err,
    input  logic [PID_W-1:0] a_id,
    output logic [SEG_W-1:0] a_base,
    output logic [LOG_W-1:0] a_log,
    input  logic [PID_W-1:0] b_id,
    output logic [SEG_W-1:0] b_base,
    output logic [LOG_W-1:0] b_log
);
    logic [NPART-1:0][SEG_W-1:0] base_q;
    logic [NPART-1:0][LOG_W-1:0] log_q;
    logic [SEG_W-1:0]            wmask;
    logic                        bad;

    // Low-bit mask of the written size, and the alignment test.
    always_comb begin
        for (int i = 0; i < SEG_W; i++) wmask[i] = (LOG_W'(i) < wlog);
        bad = (wlog > LOG_W'(SEG_W)) || ((wbase & wmask) != '0);
    end

    // Table update, with the rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPART; p++) begin
                base_q[p] <= '0;
                log_q[p]  <= LOG_W'(SEG_W);
            end
            err <= 1'b0;
        end else begin
            err <= we && bad;
            if (we && !bad) begin
                base_q[wid] <= wbase;
                log_q[wid]  <= wlog;
            end
        end
    end

    assign a_base = base_q[a_id];
    assign a_log  = log_q[a_id];
    assign b_base = base_q[b_id];
    assign b_log  = log_q[b_id];

    // R8: a rejected write left the table as it was
    a_r8_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(base_q) && $stable(log_q)));
endmodule

// File: rtl/seg_index_remap.sv
// Set index remap: each high index bit is taken from the address inside
// the partition's span and from the base outside it. One 2:1 choice per bit.
// Assumes SEG_W < IDX_W.
module seg_index_remap #(
    parameter int IDX_W = 6,
    parameter int SEG_W = 4,
    parameter int LOG_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [SEG_W-1:0] base,
    input  logic [LOG_W-1:0] span_log,
    output logic [IDX_W-1:0] set
);
    localparam int LOW_W = IDX_W - SEG_W;
    logic [SEG_W-1:0] seg;

    for (genvar g = 0; g < SEG_W; g++) begin : g_seg
        assign seg[g] = (LOG_W'(g) < span_log) ? idx[LOW_W + g] : base[g];
    end

    assign set = {seg, idx[LOW_W-1:0]};
endmodule

// File: rtl/seg_tag_store.sv
// Valid bits and full line-address tags for a direct-mapped array.
// One read, one fill write and one clear port. Fill and clear are never
// used in the same cycle.
module seg_tag_store #(
    parameter int IDX_W  = 6,
    parameter int LINE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_hit,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_set
);
    localparam int SETS = 1 << IDX_W;
    logic [SETS-1:0]   valid_q;
    logic [LINE_W-1:0] tag_q [SETS];

    // Valid bits: cleared at reset, set on fill, cleared by invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= '0;
        else if (wr_en)  valid_q[wr_set] <= 1'b1;
        else if (clr_en) valid_q[clr_set] <= 1'b0;
    end

    // Tag storage, written on fill only.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set] <= wr_line;
    end

    assign rd_hit = valid_q[rd_set] && (tag_q[rd_set] == rd_line);
endmodule

// File: rtl/seg_cache_lookup.sv
// Partitioned direct-mapped lookup: remaps the set per partition, compares
// tags, reports hit/miss one cycle later, runs a refill on a miss and
// invalidates a single partition on request. Requests that arrive while a
// refill or invalidation is in progress are dropped.
module seg_cache_lookup
    import segcache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 6,
    parameter int SEG_W  = 4,
    parameter int PID_W  = 2,
    parameter int LOG_W  = $clog2(SEG_W + 1),
    parameter int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PID_W-1:0]  cfg_pid,
    input  logic [SEG_W-1:0]  cfg_base,
    input  logic [LOG_W-1:0]  cfg_log2,
    output logic              cfg_err,
    input  logic              req_valid,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  lookup_set,
    output logic              resp_hit,
    output logic              resp_miss,
    output logic              refill_req,
    output logic [LINE_W-1:0] refill_addr,
    input  logic              refill_ack,
    input  logic              flush_start,
    input  logic [PID_W-1:0]  flush_pid,
    output logic              busy
);
    localparam int NPART = 1 << PID_W;
    localparam int LOW_W = IDX_W - SEG_W;

    lk_state_e         state_q;
    logic [SEG_W-1:0]  a_base, b_base, fmask;
    logic [LOG_W-1:0]  a_log, b_log;
    logic [IDX_W-1:0]  hold_set_q, ptr_q, last_q, first_d, last_d;
    logic [LINE_W-1:0] hold_line_q, req_line;
    logic              rd_hit, wr_en, clr_en;

    seg_part_table #(.NPART(NPART), .PID_W(PID_W), .SEG_W(SEG_W), .LOG_W(LOG_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wid(cfg_pid), .wbase(cfg_base),
        .wlog(cfg_log2), .err(cfg_err), .a_id(req_pid), .a_base(a_base),
        .a_log(a_log), .b_id(flush_pid), .b_base(b_base), .b_log(b_log)
    );

    seg_index_remap #(.IDX_W(IDX_W), .SEG_W(SEG_W), .LOG_W(LOG_W)) u_remap (
        .idx(req_addr[OFF_W +: IDX_W]), .base(a_base), .span_log(a_log),
        .set(lookup_set)
    );

    assign req_line = req_addr[ADDR_W-1:OFF_W];

    seg_tag_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_set(lookup_set), .rd_line(req_line),
        .rd_hit(rd_hit), .wr_en(wr_en), .wr_set(hold_set_q), .wr_line(hold_line_q),
        .clr_en(clr_en), .clr_set(ptr_q)
    );

    // First and last set of the partition chosen for invalidation.
    always_comb begin
        for (int i = 0; i < SEG_W; i++) fmask[i] = (LOG_W'(i) < b_log);
        first_d = {b_base, {LOW_W{1'b0}}};
        last_d  = {b_base | fmask, {LOW_W{1'b1}}};
    end

    // Control: lookup, refill wait and invalidation walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            resp_hit    <= 1'b0;
            resp_miss   <= 1'b0;
            hold_set_q  <= '0;
            hold_line_q <= '0;
            ptr_q       <= '0;
            last_q      <= '0;
        end else begin
            resp_hit  <= 1'b0;
            resp_miss <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (flush_start) begin
                        state_q <= ST_FLUSH;
                        ptr_q   <= first_d;
                        last_q  <= last_d;
                    end else if (req_valid) begin
                        if (rd_hit) begin
                            resp_hit <= 1'b1;
                        end else begin
                            resp_miss   <= 1'b1;
                            state_q     <= ST_FILL;
                            hold_set_q  <= lookup_set;
                            hold_line_q <= req_line;
                        end
                    end
                end
                ST_FILL: begin
                    if (refill_ack) begin
                        resp_hit <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_FLUSH: begin
                    if (ptr_q == last_q) state_q <= ST_IDLE;
                    else                 ptr_q   <= ptr_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_en       = (state_q == ST_FILL) && refill_ack;
    assign clr_en      = (state_q == ST_FLUSH);
    assign refill_req  = (state_q == ST_FILL);
    assign refill_addr = hold_line_q;
    assign busy        = (state_q != ST_IDLE);

    // R4: never hit and miss together
    a_r4_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_hit && resp_miss));
    // R6: refill request holds its address until acknowledged
    a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_ack) |=> (refill_req && $stable(refill_addr)));
    // R6: acknowledged refill is reported as a hit next cycle
    a_r6_hit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && refill_ack) |=> (resp_hit && !busy));
    // R9: no response while an invalidation runs
    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !refill_req) |-> (!resp_hit && !resp_miss));
    // R7: invalidation pointer never leaves its partition
    a_r7_walk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> (ptr_q <= last_q));
endmodule

// File: tb/seg_cache_lookup_tb.sv
// Behavioural reference model stepped on the clock, compared on each falling edge.
module seg_cache_lookup_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, req_valid = 0, refill_ack = 0, flush_start = 0;
    logic [1:0] cfg_pid = 0, req_pid = 0, flush_pid = 0;
    logic [3:0] cfg_base = 0;
    logic [2:0] cfg_log2 = 0;
    logic [15:0] req_addr = 0;
    logic cfg_err, resp_hit, resp_miss, refill_req, busy;
    logic [5:0] lookup_set;
    logic [13:0] refill_addr;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit done = 0;

    // reference state
    int m_base[4], m_log[4];
    bit m_valid[64];
    int m_tag[64];
    int mst = 0;              // 0 idle, 1 refill wait, 2 invalidating
    int h_set, h_line, f_ptr, f_end;
    bit e_hit, e_miss, e_err;

    always #4 clk = ~clk;     // 125 MHz

    seg_cache_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pid(cfg_pid),
        .cfg_base(cfg_base), .cfg_log2(cfg_log2), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_pid(req_pid), .req_addr(req_addr),
        .lookup_set(lookup_set), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .refill_req(refill_req), .refill_addr(refill_addr), .refill_ack(refill_ack),
        .flush_start(flush_start), .flush_pid(flush_pid), .busy(busy)
    );

    function automatic int remap(int pid, int addr);
        int seg, msk, nseg;
        seg  = (addr >> 4) & 15;
        msk  = (1 << m_log[pid]) - 1;
        nseg = (seg & msk) | (m_base[pid] & ~msk & 15);
        return nseg * 4 + ((addr >> 2) & 3);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // reference model step
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) begin m_base[p] = 0; m_log[p] = 4; end
            for (int s = 0; s < 64; s++) m_valid[s] = 0;
            mst = 0; e_hit = 0; e_miss = 0; e_err = 0;
        end else begin
            e_hit = 0; e_miss = 0;
            if (mst == 0) begin
                if (flush_start) begin
                    mst = 2;
                    f_ptr = m_base[flush_pid] * 4;
                    f_end = f_ptr + (1 << m_log[flush_pid]) * 4 - 1;
                end else if (req_valid) begin
                    int s;
                    s = remap(req_pid, req_addr);
                    if (m_valid[s] && m_tag[s] == (req_addr >> 2)) e_hit = 1;
                    else begin
                        e_miss = 1; mst = 1; h_set = s; h_line = req_addr >> 2;
                    end
                end
            end else if (mst == 1) begin
                if (refill_ack) begin
                    m_valid[h_set] = 1; m_tag[h_set] = h_line; e_hit = 1; mst = 0;
                end
            end else begin
                m_valid[f_ptr] = 0;
                if (f_ptr == f_end) mst = 0; else f_ptr++;
            end
            e_err = cfg_we && (cfg_log2 > 4 || (cfg_base & ((1 << cfg_log2) - 1)) != 0);
            if (cfg_we && !e_err) begin m_base[cfg_pid] = cfg_base; m_log[cfg_pid] = cfg_log2; end
        end
    end

    // comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4/R5/R9 resp_hit", resp_hit, e_hit);
            check("R4/R5/R9 resp_miss", resp_miss, e_miss);
            check("R6 refill_req", refill_req, mst == 1);
            if (mst == 1) check("R6 refill_addr", refill_addr, h_line);
            check("R7 busy", busy, mst != 0);
            check("R8 cfg_err", cfg_err, e_err);
            check("R2/R3 lookup_set", lookup_set, remap(req_pid, req_addr));
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic cfg(int pid, int base, int lg);
        cfg_we = 1; cfg_pid = 2'(pid); cfg_base = 4'(base); cfg_log2 = 3'(lg);
        tick(); cfg_we = 0;
    endtask

    // one lookup; on a miss, acknowledge after dly cycles, issuing ignored requests meanwhile
    task automatic access(int pid, int addr, int dly);
        req_valid = 1; req_pid = 2'(pid); req_addr = 16'(addr);
        tick(); req_valid = 0;
        if (mst == 1) begin
            for (int i = 0; i < dly; i++) begin
                req_valid = 1; req_addr = 16'(addr ^ 16'h0440); tick(); req_valid = 0;
            end
            refill_ack = 1; tick(); refill_ack = 0;
        end
        tick();
    endtask

    task automatic flush(int pid, bit with_req);
        flush_start = 1; flush_pid = 2'(pid); req_valid = with_req; req_addr = 16'h0010;
        tick(); flush_start = 0;
        while (mst == 2) begin req_valid = 1; tick(); end
        req_valid = 0; tick();
    endtask

    initial begin
        int x;
        repeat (3) tick();
        rst_n = 1;
        @(negedge clk);
        check("R1 reset busy", busy, 0);
        check("R1 reset refill_req", refill_req, 0);
        check("R1 reset hit", resp_hit, 0);
        check("R1 reset err", cfg_err, 0);
        tick();
        access(0, 16'h1234, 1);                    // R1: cold miss on whole-cache partition
        access(0, 16'h1234, 0);                    // R4: hit
        cfg(1, 8, 3); cfg(2, 4, 2); cfg(3, 3, 0);
        cfg(2, 6, 2);                              // R8: misaligned
        cfg(3, 0, 5);                              // R8: size too large
        access(1, 16'h1234, 2);                    // R5: different slice, miss
        access(2, 16'h1234, 3);
        access(1, 16'h1234, 0);                    // R5: still present
        access(2, 16'h1234, 0);
        access(3, 16'hABF0, 1);
        access(3, 16'h0000, 0);                    // R2: forced to segment 3
        flush(2, 1);                               // R7 with simultaneous request
        access(2, 16'h1234, 1);                    // R7: gone
        access(1, 16'h1234, 0);                    // R7: kept
        flush(3, 0);
        flush(0, 0);
        x = 7;
        for (int n = 0; n < 400; n++) begin
            x = x * 1103515245 + 12345;
            if (((x >> 24) & 31) == 0) cfg((x >> 8) & 3, (x >> 12) & 15, (x >> 16) & 7);
            else if (((x >> 24) & 31) == 1) flush((x >> 8) & 3, 1);
            else access((x >> 4) & 3, (((x >> 12) & 3) << 10) | (((x >> 16) & 63) << 2), (x >> 20) & 3);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule